// File: doc/BRIEF.md
# Dual Waveform Output Selector for a Real-Time Clock

This block drives two output pins, each of which can carry any one of eight signals. The choices are a constant low level, four square waves at 1 Hz, 32 Hz, 64 Hz and 512 Hz, a level that flips each time the alarm flag rises, a direct copy of the alarm flag, or a pulse train. For the pulse train, both the period and the high time are picked from small coded tables. All timing comes from a single free-running 16-bit counter. This counter advances on a tick enable at 65.536 kHz, which is twice the 32.768 kHz slow-clock rate.

A 32-bit mode word supplies the two 3-bit source selectors, the 3-bit high-time code and the 2-bit period code. Both pins use the same pulse settings. Each pin is a register that loads only on a tick. A change to the mode word therefore shows up at the next tick, and the shared counter keeps running through the change.

Top module: `rtc_wave_out`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, both outputs are low. The tick counter and the alarm toggle state both start at zero.
- R2: Selector code 0 makes the output low at every tick.
- R3: Selector codes 1, 2, 3 and 4 give square waves with 50% duty. Their periods are 65536, 2048, 1024 and 128 ticks. The output is high in the second half of each period, counted from a tick count of zero.
- R4: Output 0 takes its selector from mode bits 18:16 and output 1 from mode bits 22:20. The two outputs are independent of each other. Mode bits 15:0, 19, 23, 27, 31 and 30 have no effect.
- R5: Selector code 5 outputs a toggle state. This state starts at 0 and flips at each clock edge where the alarm flag is high after being low at the previous edge.
- R6: Selector code 6 outputs the alarm flag as sampled at the tick edge.
- R7: Selector code 7 outputs a pulse whose period comes from mode bits 29:28. Codes 0 to 3 give 65536, 32768, 16384 and 8192 ticks. The pulse is high at phase zero of each period.
- R8: The pulse high time comes from mode bits 26:24. Codes 0 to 7 give 2048, 1024, 256, 64, 32, 8, 2 and 1 ticks. After that many ticks the pulse goes low.
- R9: The outputs change only at clock edges where tick is high. At such an edge, an output takes the value its source had for the count held before that edge. A new selector takes effect at the next tick, and the count is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 65.536 kHz advance enable, one clock wide |
| alarm_flag | input | 1 | Alarm match flag |
| mode | input | 32 | Mode word holding the selectors and the pulse fields |
| wave0 | output | 1 | Waveform output 0 |
| wave1 | output | 1 | Waveform output 1 |

## Verification
The hardest cases to reach are the long-period ones: the 1 Hz square wave and the 1 s pulse period each take 65536 ticks to complete. The bench holds tick high on every clock for the first sweeps, so the counter covers a full wrap quickly. It then walks every high-time code against the shortest period, starting each segment exactly at phase zero. The alarm-driven sources are tested with tick running at one third of the clock rate. This lets alarm edges fall between ticks, including one-cycle alarm pulses that only the toggle state can record.

// File: rtl/rtc_wave_out.sv
module rtc_wave_out #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        alarm_flag,
  input  logic [31:0] mode,
  output logic        wave0,
  output logic        wave1
);
  localparam int SQ1_BIT   = CNT_W - 1;
  localparam int SQ32_BIT  = CNT_W - 6;
  localparam int SQ64_BIT  = CNT_W - 7;
  localparam int SQ512_BIT = CNT_W - 10;
  localparam int SEL0_LSB  = 16;
  localparam int SEL1_LSB  = 20;

  logic [CNT_W-1:0] tick_cnt;
  logic             alarm_d, alarm_tgl;
  logic [2:0]       hi_code;
  logic [1:0]       per_code;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] hi_len;
  logic             pulse;
  logic [1:0]       wave_q, wave_nxt;
  logic             unused_mode;

  assign hi_code     = mode[26:24];
  assign per_code    = mode[29:28];
  assign unused_mode = ^{mode[31:30], mode[27], mode[23], mode[19], mode[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      alarm_d   <= 1'b0;
      alarm_tgl <= 1'b0;
    end else begin
      alarm_d <= alarm_flag;
      if (alarm_flag && !alarm_d) alarm_tgl <= ~alarm_tgl;
      if (tick) tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_comb begin
    case (hi_code)
      3'd0:    hi_len = CNT_W'(2048);
      3'd1:    hi_len = CNT_W'(1024);
      3'd2:    hi_len = CNT_W'(256);
      3'd3:    hi_len = CNT_W'(64);
      3'd4:    hi_len = CNT_W'(32);
      3'd5:    hi_len = CNT_W'(8);
      3'd6:    hi_len = CNT_W'(2);
      default: hi_len = CNT_W'(1);
    endcase
  end

  assign phase = tick_cnt & ({CNT_W{1'b1}} >> per_code);
  assign pulse = phase < hi_len;

  for (genvar g = 0; g < 2; g++) begin : g_out
    logic [SEL_W-1:0] sel;
    assign sel = mode[(g == 0 ? SEL0_LSB : SEL1_LSB) +: SEL_W];

    always_comb begin
      case (sel)
        3'd0:    wave_nxt[g] = 1'b0;
        3'd1:    wave_nxt[g] = tick_cnt[SQ1_BIT];
        3'd2:    wave_nxt[g] = tick_cnt[SQ32_BIT];
        3'd3:    wave_nxt[g] = tick_cnt[SQ64_BIT];
        3'd4:    wave_nxt[g] = tick_cnt[SQ512_BIT];
        3'd5:    wave_nxt[g] = alarm_tgl;
        3'd6:    wave_nxt[g] = alarm_flag;
        default: wave_nxt[g] = pulse;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    wave_q[g] <= 1'b0;
      else if (tick) wave_q[g] <= wave_nxt[g];
    end
  end

  assign wave0 = wave_q[0];
  assign wave1 = wave_q[1];
endmodule

// File: rtl/rtc_wave_out_chk.sv
module rtc_wave_out_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        alarm_flag,
  input logic [31:0] mode,
  input logic        wave0,
  input logic        wave1,
  input logic [15:0] cnt
);
  // R9
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(wave0));
  // R9
  hold1_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(wave1));
  // R2
  low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode[18:16] == 3'd0 |=> !wave0);
  // R6
  copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode[22:20] == 3'd6 |=> wave1 == $past(alarm_flag));
  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode[18:16] == 3'd7 && (cnt & (16'hFFFF >> mode[29:28])) == 16'd0 |=> wave0);
  // R1
  reset_chk: assert property (@(posedge clk) !rst_n |=> !wave0 && !wave1 && cnt == 16'd0);
endmodule

bind rtc_wave_out rtc_wave_out_chk chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_flag(alarm_flag),
  .mode(mode), .wave0(wave0), .wave1(wave1), .cnt(tick_cnt)
);

// File: tb/rtc_wave_out_test.sv
module rtc_wave_out_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 199000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, alarm_flag = 1'b0;
  logic [31:0] mode = '0;
  logic wave0, wave1;
  int tests = 0, fails = 0, cycles = 0;

  rtc_wave_out uut (.clk(clk), .rst_n(rst_n), .tick(tick), .alarm_flag(alarm_flag),
                    .mode(mode), .wave0(wave0), .wave1(wave1));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic ref_wave(input logic [2:0] s, input int unsigned m,
                                    input logic [2:0] h, input logic [1:0] p,
                                    input logic a, input logic t);
    int unsigned hi, per, mm;
    mm = m % 65536;
    case (h)
      0: hi = 2048; 1: hi = 1024; 2: hi = 256; 3: hi = 64;
      4: hi = 32;   5: hi = 8;    6: hi = 2;   default: hi = 1;
    endcase
    per = 65536 / (1 << p);
    case (s)
      0: return 1'b0;
      1: return ((mm / 32768) % 2) == 1;
      2: return ((mm / 1024) % 2) == 1;
      3: return ((mm / 512) % 2) == 1;
      4: return ((mm / 64) % 2) == 1;
      5: return t;
      6: return a;
      default: return (mm % per) < hi;
    endcase
  endfunction

  int unsigned mcnt;
  logic mtgl, malm_d;
  logic [1:0] expv;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      mcnt <= 0; mtgl <= 1'b0; malm_d <= 1'b0; expv <= 2'b00;
    end else begin
      malm_d <= alarm_flag;
      if (alarm_flag && !malm_d) mtgl <= ~mtgl;
      if (tick) begin
        expv[0] <= ref_wave(mode[18:16], mcnt, mode[26:24], mode[29:28], alarm_flag, mtgl);
        expv[1] <= ref_wave(mode[22:20], mcnt, mode[26:24], mode[29:28], alarm_flag, mtgl);
        mcnt <= mcnt + 1;
      end
    end
  end

  function automatic logic [31:0] mk(input logic [2:0] s0, input logic [2:0] s1,
                                     input logic [2:0] h, input logic [1:0] p);
    return {2'b11, p, 1'b1, h, 1'b1, s1, 1'b1, s0, 16'hA5C3};
  endfunction

  task automatic check(input logic act, input logic ex, input string tag, input int o);
    tests++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s R4 out%0d got %b expected %b (cycle %0d)", tag, o, act, ex, cycles);
    end
  endtask

  task automatic seg(input int n, input int div, input logic alm, input logic [31:0] md,
                     input string tag);
    mode = md;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(wave0, expv[0], tag, 0);
      check(wave1, expv[1], tag, 1);
      tick = (i % div) == 0;
      if (alm) alarm_flag = ((i % 13) == 5) || ((i % 29) >= 20);
      else alarm_flag = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs low under reset
    tests++;
    if (wave0 !== 1'b0 || wave1 !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset got %b%b expected 00", wave0, wave1);
    end
    rst_n = 1'b1;
    // R3 R7 R8: full 1 Hz wrap, 1 s pulse with 2048-tick high
    seg(65536, 1, 1'b0, mk(3'd1, 3'd7, 3'd0, 2'd0), "R3 R7 R8");
    // R8 R3: every high-time code on the 8192-tick period
    for (int h = 0; h < 8; h++)
      seg(8192, 1, 1'b0, mk(3'(2 + h % 3), 3'd7, 3'(h), 2'd3), "R8 R3 R9");
    // R7 R2: the 500 ms and 250 ms periods
    seg(8192, 1, 1'b0, mk(3'd0, 3'd7, 3'd1, 2'd1), "R7 R2");
    seg(8192, 1, 1'b0, mk(3'd7, 3'd0, 3'd2, 2'd2), "R7 R2");
    // R5 R6 R9: alarm sources with gapped tick
    seg(4000, 3, 1'b1, mk(3'd5, 3'd6, 3'd0, 2'd0), "R5 R6 R9");
    seg(2000, 3, 1'b1, mk(3'd6, 3'd5, 3'd4, 2'd3), "R5 R6 R9");
    seg(1000, 5, 1'b1, mk(3'd7, 3'd4, 3'd6, 2'd3), "R9 R7");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired got running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule